// File: doc/BRIEF.md
# Lane-Preserving Warp Compactor

This block takes the active mask of a whole thread block, laid out as `NUM_WARPS` static warps of `LANES` lanes each, and turns it into a short series of dense dynamic warps. Each lane position has its own selector, and that selector looks only at its own column of the mask. On every cycle, each selector picks the remaining active thread with the lowest warp index in its column. It then removes that thread from the column. The picks of all lanes together form one output warp. A thread therefore always stays in its home lane, so the register file path needs no crossbar.

The controller has three states. `ST_IDLE` waits for `start_i`. `ST_EMIT` presents one warp per cycle. `ST_FINISH` raises `done_o` for exactly one cycle and then returns to idle.

The named transitions are:
- `GO` moves from `ST_IDLE` to `ST_EMIT` when a start arrives with a non-zero mask.
- `EMPTY` moves from `ST_IDLE` to `ST_FINISH` when a start arrives with an all-zero mask.
- `STAY` keeps the block in `ST_EMIT` while any column still holds threads after the current pick.
- `LAST` moves from `ST_EMIT` to `ST_FINISH` once no column holds threads after the current pick.
- `RETIRE` moves from `ST_FINISH` back to `ST_IDLE`.

Top module: `warp_compactor`

## Requirements
- R1: During and right after reset, `warp_valid_o`, `busy_o`, `done_o` and every bit of `lane_valid_o` are 0.
- R2: The block samples `start_i` in `ST_IDLE` together with `mask_i`. Bit `w*LANES + l` of `mask_i` marks thread `w*LANES + l` (warp `w`, lane `l`) as active. The first output warp appears in the cycle after the start.
- R3: In every emitted warp, lane `l` carries the active thread that has not yet been emitted and has the lowest warp index in column `l`. Its ID is `w*LANES + l` and is placed in field `l` of `lane_tid_o`. That thread is then not emitted again.
- R4: A lane whose column has no remaining thread has `lane_valid_o[l]` = 0 and a thread ID of 0. When `warp_valid_o` is 0, all lane valid bits are 0.
- R5: Warps are emitted on consecutive cycles. Their number equals the largest count of active bits in any single lane column, and every emitted warp holds at least one thread.
- R6: `done_o` is high for exactly one cycle, the cycle after the last warp. In that cycle `warp_valid_o` and `busy_o` are 0.
- R7: When the mask is all zeros, no warp is emitted and `done_o` is raised in the cycle after the start.
- R8: A `start_i` that arrives while warps are being emitted is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Loads `mask_i` when the block is idle |
| mask_i | input | NUM_WARPS*LANES | Block-wide active mask, bit `w*LANES+l` |
| warp_valid_o | output | 1 | A compacted warp is presented this cycle |
| lane_valid_o | output | LANES | Per-lane slot valid bits |
| lane_tid_o | output | LANES*TID_W | Per-lane thread IDs, field `l` at bits `l*TID_W` upward |
| busy_o | output | 1 | Block is emitting warps |
| done_o | output | 1 | One-cycle pulse after the final warp |

## Verification
The hardest situation to reach from the ports is a new start arriving in the middle of an emission run. That stimulus must land while the columns are only partly drained, and the bench must then show that every later warp still follows the original mask. The bench does this by raising `start_i` with a different mask in the cycle it samples the first warp of a four-warp run. It then checks every later warp against a model of the original mask. Columns of unequal depth, with gaps between active warps, are covered by table entries whose column counts differ. This exercises invalid slots that appear in the middle of the sequence.

// File: rtl/wc_pkg.sv
package wc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_FINISH = 2'd2
    } wc_state_e;
endpackage

// File: rtl/wc_lane_encoder.sv
module wc_lane_encoder #(
    parameter int NUM_WARPS = 4,
    localparam int WIDX_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [NUM_WARPS-1:0] col_i,
    input  logic                 advance_i,
    output logic                 hit_o,
    output logic [WIDX_W-1:0]    widx_o,
    output logic                 remain_o
);
    logic [NUM_WARPS-1:0] col_q;
    logic [NUM_WARPS-1:0] pick;

    // isolate lowest set bit of the column
    always_comb begin
        pick = col_q & (~col_q + {{(NUM_WARPS-1){1'b0}}, 1'b1});
    end

    always_comb begin
        widx_o = '0;
        for (int w = NUM_WARPS - 1; w >= 0; w--) begin
            if (col_q[w]) begin
                widx_o = WIDX_W'(w);
            end
        end
    end

    assign hit_o    = |col_q;
    assign remain_o = |(col_q & ~pick);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (load_i) begin
            col_q <= col_i;
        end else if (advance_i) begin
            col_q <= col_q & ~pick;
        end
    end

    AST_COL_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !load_i && hit_o) |=> ($countones(col_q) == $countones($past(col_q)) - 1)); // R3
    AST_COL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && !load_i) |=> $stable(col_q)); // R8
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl
    import wc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mask_nz_i,
    input  logic more_i,
    output logic load_o,
    output logic advance_o,
    output logic warp_valid_o,
    output logic busy_o,
    output logic done_o
);
    wc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = mask_nz_i ? ST_EMIT : ST_FINISH;   // GO / EMPTY
                end
            end
            ST_EMIT: begin
                state_d = more_i ? ST_EMIT : ST_FINISH;          // STAY / LAST
            end
            ST_FINISH: begin
                state_d = ST_IDLE;                               // RETIRE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load_o       = 1'b0;
        advance_o    = 1'b0;
        warp_valid_o = 1'b0;
        busy_o       = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_o = start_i;
            ST_EMIT: begin
                advance_o    = 1'b1;
                warp_valid_o = 1'b1;
                busy_o       = 1'b1;
            end
            ST_FINISH: done_o = 1'b1;
            default: ;
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_ZERO_MASK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && !mask_nz_i) |=> (done_o && !warp_valid_o)); // R7
    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_o); // R8
endmodule

// File: rtl/warp_compactor.sv
module warp_compactor #(
    parameter int NUM_WARPS = 4,
    parameter int LANES     = 4,
    localparam int THREADS  = NUM_WARPS * LANES,
    localparam int TID_W    = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int WIDX_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [THREADS-1:0]       mask_i,
    output logic                     warp_valid_o,
    output logic [LANES-1:0]         lane_valid_o,
    output logic [LANES*TID_W-1:0]   lane_tid_o,
    output logic                     busy_o,
    output logic                     done_o
);
    logic             load;
    logic             advance;
    logic [LANES-1:0] hit;
    logic [LANES-1:0] remain;

    wc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mask_nz_i    (|mask_i),
        .more_i       (|remain),
        .load_o       (load),
        .advance_o    (advance),
        .warp_valid_o (warp_valid_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [NUM_WARPS-1:0] column;
        logic [WIDX_W-1:0]    widx;

        for (genvar w = 0; w < NUM_WARPS; w++) begin : g_col
            assign column[w] = mask_i[w*LANES + l];
        end

        wc_lane_encoder #(.NUM_WARPS(NUM_WARPS)) u_enc (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load),
            .col_i     (column),
            .advance_i (advance),
            .hit_o     (hit[l]),
            .widx_o    (widx),
            .remain_o  (remain[l])
        );

        assign lane_valid_o[l] = warp_valid_o & hit[l];
        assign lane_tid_o[l*TID_W +: TID_W] = lane_valid_o[l]
            ? TID_W'(TID_W'(widx) * TID_W'(LANES) + TID_W'(l)) : '0;
    end

    AST_WARP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid_o |-> (|lane_valid_o)); // R5
    AST_LANES_NEED_WARP: assert property (@(posedge clk) disable iff (!rst_n)
        !warp_valid_o |-> (lane_valid_o == '0)); // R4
    AST_VALID_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid_o |-> !done_o); // R6
endmodule

// File: tb/warp_compactor_bench.sv
module warp_compactor_bench;
    localparam int NW  = 4;
    localparam int LN  = 4;
    localparam int TH  = NW * LN;
    localparam int TW  = $clog2(TH);
    localparam int NVEC = 9;

    typedef struct packed {
        logic [TH-1:0] mask;
        logic [3:0]    count;
    } vec_t;

    // stimulus mask and expected number of output warps
    localparam vec_t VECS [NVEC] = '{
        '{16'h0CD3, 4'd2}, '{16'hFFFF, 4'd4}, '{16'h0001, 4'd1},
        '{16'h8000, 4'd1}, '{16'h1111, 4'd4}, '{16'h000F, 4'd1},
        '{16'h8421, 4'd1}, '{16'h0F0F, 4'd2}, '{16'hA052, 4'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [TH-1:0] mask_i = '0;
    logic warp_valid_o, busy_o, done_o;
    logic [LN-1:0] lane_valid_o;
    logic [LN*TW-1:0] lane_tid_o;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    warp_compactor #(.NUM_WARPS(NW), .LANES(LN)) u_warp_compactor (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .warp_valid_o(warp_valid_o), .lane_valid_o(lane_valid_o),
        .lane_tid_o(lane_tid_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // run one mask; optionally inject a foreign start during the first warp
    task automatic run_mask(input logic [TH-1:0] m, input int exp_cnt, input bit inject);
        logic [TH-1:0] rem;
        int emitted;
        rem = m;
        emitted = 0;
        @(negedge clk);
        start_i = 1'b1;
        mask_i  = m;
        @(negedge clk);
        start_i = 1'b0;
        while (rem != '0 && emitted < 8) begin
            check(warp_valid_o === 1'b1, "R5 warp_valid", int'(warp_valid_o), 1);
            for (int l = 0; l < LN; l++) begin
                int ew;
                ew = -1;
                for (int w = NW - 1; w >= 0; w--) if (rem[w*LN + l]) ew = w;
                if (ew >= 0) begin
                    check(lane_valid_o[l] === 1'b1, "R3 lane valid", int'(lane_valid_o[l]), 1);
                    check(int'(lane_tid_o[l*TW +: TW]) == ew*LN + l, "R3 lane tid",
                          int'(lane_tid_o[l*TW +: TW]), ew*LN + l);
                    rem[ew*LN + l] = 1'b0;
                end else begin
                    check(lane_valid_o[l] === 1'b0, "R4 empty lane valid", int'(lane_valid_o[l]), 0);
                    check(lane_tid_o[l*TW +: TW] == '0, "R4 empty lane tid",
                          int'(lane_tid_o[l*TW +: TW]), 0);
                end
            end
            check(done_o === 1'b0, "R6 no early done", int'(done_o), 0);
            emitted++;
            if (inject && emitted == 1) begin
                start_i = 1'b1;           // R8: must be ignored
                mask_i  = 16'h0001;
            end
            @(negedge clk);
            start_i = 1'b0;
            mask_i  = m;
        end
        check(emitted == exp_cnt, "R5 warp count", emitted, exp_cnt);
        check(warp_valid_o === 1'b0, "R6 valid after last", int'(warp_valid_o), 0);
        check(done_o === 1'b1, (m == '0) ? "R7 done for zero mask" : "R6 done pulse", int'(done_o), 1);
        check(busy_o === 1'b0, "R6 not busy at done", int'(busy_o), 0);
        @(negedge clk);
        check(done_o === 1'b0, "R6 done one cycle", int'(done_o), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(warp_valid_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0 && lane_valid_o === '0,
              "R1 reset outputs", int'(warp_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(warp_valid_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
              "R1 idle after reset", int'(busy_o), 0);
        // R2 R3 R4 R5 R6: table walk
        for (int i = 0; i < NVEC; i++) begin
            run_mask(VECS[i].mask, int'(VECS[i].count), 1'b0);
        end
        // R7: all-zero mask
        run_mask('0, 0, 1'b0);
        // R8: start while emitting is ignored
        run_mask(16'hFFFF, 4, 1'b1);
        run_mask(16'h0CD3, 2, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule